// File: doc/BRIEF.md
# Indirect Register Access Bridge

This bridge lets a host reach a private register space that is not mapped on the host bus. The host sees two 32-bit registers: a data register and a command register. Placing a command word in the command register starts one single-beat access on an inner port whose latency varies from access to access. The command word carries the inner word offset in its low bits and a direction bit. For a write, the value already held in the data register is sent to the inner address. For a read, the returned value is placed in the data register.

While an access is outstanding, a busy flag shows in the command register. Host writes that arrive during that time are dropped. A dropped command also sets a sticky overrun flag. A watchdog ends any access whose acknowledge never comes, so busy always clears within a bounded time. Software can therefore poll with a fixed retry limit.

Top module: `ibr_bridge`

## Requirements
- R1: After reset the data register reads 0, the command register reads 0 (busy clear, both error flags clear) and `inner_req` is low.
- R2: A host write to offset 0x0 while idle updates the data register, and the new value reads back at offset 0x0 on the following cycle.
- R3: A host write to offset 0x4 while idle is accepted. In the next cycle `inner_req` is high, `inner_we` equals bit 28 of the written word (1 = write, 0 = read), `inner_addr` equals the low `IAW` bits of the word, and `inner_wdata` equals the data register.
- R4: On a read access, the `inner_rdata` value that is present when `inner_ack` is sampled high is loaded into the data register. It is readable once busy has cleared.
- R5: Bit 31 of the command register reads 1 from the cycle after acceptance through the cycle in which `inner_ack` is high, and reads 0 on the following cycle. `inner_req` follows the same window, so an ack in busy cycle L gives exactly L busy cycles.
- R6: A host write to offset 0x4 while busy is ignored, so the inner address and direction stay unchanged. It sets the sticky overrun flag at bit 27 of the command register.
- R7: A host write to offset 0x0 while busy is ignored, and the data register keeps its value.
- R8: If no ack arrives within `WDOG_CYCLES` busy cycles, the access is forced to end. Busy and `inner_req` are then low after exactly `WDOG_CYCLES` busy cycles, the timeout flag at bit 27's neighbour, bit 26, is set, and the data register is unchanged.
- R9: The command register reads back the accepted direction in bit 28 and the address in its low bits. Both error flags are cleared by the next accepted command.
- R10: An `inner_ack` that arrives while idle has no effect: the data register and busy flag are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_addr | input | HOST_AW | Host byte offset: 0x0 data, 0x4 command |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read value of the register selected by host_addr |
| inner_req | output | 1 | Inner access request, held until ack or timeout |
| inner_we | output | 1 | Inner access direction, 1 = write |
| inner_addr | output | IAW | Inner word offset |
| inner_wdata | output | 32 | Inner write data |
| inner_ack | input | 1 | Inner access completion, one cycle |
| inner_rdata | input | 32 | Inner read data, valid with inner_ack |

## Verification
The assertions assume that `inner_ack` is a single-cycle pulse that comes only while a request is outstanding. The one exception is the idle ack that R10 covers on purpose. They also assume that `inner_rdata` is valid in the cycle of the ack. The bench's inner model drives the ack and the read data together at the falling edge in one chosen busy cycle, and drops the ack as soon as the request falls. The only stray ack is a deliberate one-cycle pulse given while the bridge is idle. Host strobes are likewise driven at falling edges and held for exactly one cycle, so every command and data write falls into a known busy or idle cycle.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
  localparam int BUSY_BIT  = 31;
  localparam int WRITE_BIT = 28;
  localparam int OVR_BIT   = 27;
  localparam int TMO_BIT   = 26;

  // Compose the command register read view from its state bits.
  function automatic logic [31:0] cmd_view(input logic busy, input logic we,
                                           input logic ovr, input logic tmo,
                                           input logic [31:0] addr_ext);
    logic [31:0] v;
    v = addr_ext;
    v[BUSY_BIT]  = busy;
    v[WRITE_BIT] = we;
    v[OVR_BIT]   = ovr;
    v[TMO_BIT]   = tmo;
    return v;
  endfunction

  // Number of busy cycles an access lasts for a given ack latency.
  function automatic int busy_span(input int ack_lat, input int limit);
    if (ack_lat == 0 || ack_lat > limit) return limit;
    return ack_lat;
  endfunction
endpackage

// File: rtl/ibr_host_decode.sv
module ibr_host_decode #(
  parameter int HOST_AW  = 4,
  parameter int DATA_OFS = 0,
  parameter int CMD_OFS  = 4
) (
  input  logic               host_wr_en,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic               busy,
  output logic               data_wr_ok,
  output logic               data_wr_drop,
  output logic               cmd_accept,
  output logic               cmd_overrun
);
  logic hit_data, hit_cmd;

  assign hit_data     = host_wr_en && (host_addr == HOST_AW'(DATA_OFS));
  assign hit_cmd      = host_wr_en && (host_addr == HOST_AW'(CMD_OFS));
  assign data_wr_ok   = hit_data && !busy;
  assign data_wr_drop = hit_data && busy;
  assign cmd_accept   = hit_cmd && !busy;
  assign cmd_overrun  = hit_cmd && busy;
endmodule

// File: rtl/ibr_watchdog.sv
module ibr_watchdog #(
  parameter int LIMIT = 64,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  input  logic hit,
  output logic expire
);
  logic [CW-1:0] cnt_q;

  assign expire = run && !hit && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (start)  cnt_q <= '0;
    else if (run && !expire) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ibr_seq.sv
module ibr_seq #(
  parameter int IAW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_accept,
  input  logic           cmd_overrun,
  input  logic           cmd_we,
  input  logic [IAW-1:0] cmd_addr,
  input  logic           inner_ack,
  input  logic           wdog_expire,
  output logic           busy,
  output logic           we,
  output logic [IAW-1:0] addr,
  output logic           ovr,
  output logic           tmo,
  output logic           access_done,
  output logic           read_capture
);
  logic busy_q, we_q, ovr_q, tmo_q;
  logic [IAW-1:0] addr_q;
  logic force_done;

  assign access_done  = busy_q && inner_ack;
  assign force_done   = busy_q && wdog_expire;
  assign read_capture = access_done && !we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      we_q   <= 1'b0;
      addr_q <= '0;
      ovr_q  <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      if (cmd_accept) begin
        busy_q <= 1'b1;
        we_q   <= cmd_we;
        addr_q <= cmd_addr;
        ovr_q  <= 1'b0;
        tmo_q  <= 1'b0;
      end else begin
        if (access_done || force_done) busy_q <= 1'b0;
        if (force_done)  tmo_q <= 1'b1;
        if (cmd_overrun) ovr_q <= 1'b1;
      end
    end
  end

  assign busy = busy_q;
  assign we   = we_q;
  assign addr = addr_q;
  assign ovr  = ovr_q;
  assign tmo  = tmo_q;
endmodule

// File: rtl/ibr_bridge.sv
module ibr_bridge #(
  parameter int HOST_AW     = 4,
  parameter int IAW         = 16,
  parameter int WDOG_CYCLES = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr_en,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  output logic               inner_req,
  output logic               inner_we,
  output logic [IAW-1:0]     inner_addr,
  output logic [31:0]        inner_wdata,
  input  logic               inner_ack,
  input  logic [31:0]        inner_rdata
);
  import ibr_pkg::*;
  localparam int DATA_OFS = 0;
  localparam int CMD_OFS  = 4;

  logic data_wr_ok, data_wr_drop, cmd_accept, cmd_overrun;
  logic busy, we, ovr, tmo, access_done, read_capture, wdog_expire;
  logic [IAW-1:0] addr;
  logic [31:0] data_q;
  logic cmd_unused;

  assign cmd_unused = ^{host_wdata[31:WRITE_BIT+1], host_wdata[WRITE_BIT-1:IAW]};

  ibr_host_decode #(.HOST_AW(HOST_AW), .DATA_OFS(DATA_OFS), .CMD_OFS(CMD_OFS)) dec_i (
    .host_wr_en  (host_wr_en),
    .host_addr   (host_addr),
    .busy        (busy),
    .data_wr_ok  (data_wr_ok),
    .data_wr_drop(data_wr_drop),
    .cmd_accept  (cmd_accept),
    .cmd_overrun (cmd_overrun)
  );

  ibr_watchdog #(.LIMIT(WDOG_CYCLES)) wdog_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (cmd_accept),
    .run   (busy),
    .hit   (inner_ack),
    .expire(wdog_expire)
  );

  ibr_seq #(.IAW(IAW)) seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_accept  (cmd_accept),
    .cmd_overrun (cmd_overrun),
    .cmd_we      (host_wdata[WRITE_BIT]),
    .cmd_addr    (host_wdata[IAW-1:0]),
    .inner_ack   (inner_ack),
    .wdog_expire (wdog_expire),
    .busy        (busy),
    .we          (we),
    .addr        (addr),
    .ovr         (ovr),
    .tmo         (tmo),
    .access_done (access_done),
    .read_capture(read_capture)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            data_q <= '0;
    else if (data_wr_ok)   data_q <= host_wdata;
    else if (read_capture) data_q <= inner_rdata;
  end

  always_comb begin
    if (host_addr == HOST_AW'(DATA_OFS))
      host_rdata = data_q;
    else if (host_addr == HOST_AW'(CMD_OFS))
      host_rdata = cmd_view(busy, we, ovr, tmo, {{(32-IAW){1'b0}}, addr});
    else
      host_rdata = '0;
  end

  assign inner_req   = busy;
  assign inner_we    = we;
  assign inner_addr  = addr;
  assign inner_wdata = data_q;
endmodule

// File: rtl/ibr_bridge_chk.sv
module ibr_bridge_chk #(
  parameter int IAW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic [31:0]    host_wdata,
  input logic           inner_req,
  input logic           inner_we,
  input logic [IAW-1:0] inner_addr,
  input logic           inner_ack,
  input logic           cmd_accept,
  input logic           cmd_overrun,
  input logic           data_wr_drop,
  input logic           wdog_expire,
  input logic [31:0]    data_q,
  input logic           ovr,
  input logic           tmo
);
  // R3
  accept_starts_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> inner_req && (inner_we == $past(host_wdata[28])));
  // R5
  ack_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inner_req && inner_ack |=> !inner_req);
  // R6
  overrun_keeps_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_overrun |=> $stable(inner_addr) && ovr);
  // R7
  busy_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr_drop && !inner_ack |=> $stable(data_q));
  // R8
  wdog_forces_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_expire |=> !inner_req && tmo);
  // R10
  idle_ack_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inner_req && inner_ack && !cmd_accept |=> !inner_req && $stable(data_q));
endmodule

bind ibr_bridge ibr_bridge_chk #(.IAW(IAW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_wdata  (host_wdata),
  .inner_req   (inner_req),
  .inner_we    (inner_we),
  .inner_addr  (inner_addr),
  .inner_ack   (inner_ack),
  .cmd_accept  (cmd_accept),
  .cmd_overrun (cmd_overrun),
  .data_wr_drop(data_wr_drop),
  .wdog_expire (wdog_expire),
  .data_q      (data_q),
  .ovr         (ovr),
  .tmo         (tmo)
);

// File: tb/ibr_bridge_tb_top.sv
`timescale 1ns/1ps
module ibr_bridge_tb_top;
  localparam int W   = 8;
  localparam int IAW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr_en = 1'b0;
  logic [3:0] host_addr = 4'h0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic inner_req, inner_we;
  logic [IAW-1:0] inner_addr;
  logic [31:0] inner_wdata;
  logic model_ack = 1'b0, stray_ack = 1'b0;
  logic [31:0] model_rdata = '0;
  logic inner_ack;
  logic [31:0] inner_rdata;

  assign inner_ack   = model_ack | stray_ack;
  assign inner_rdata = stray_ack ? 32'hBAD0_BAD0 : model_rdata;

  always #4 clk = ~clk;

  ibr_bridge #(.HOST_AW(4), .IAW(IAW), .WDOG_CYCLES(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .inner_req(inner_req),
    .inner_we(inner_we), .inner_addr(inner_addr), .inner_wdata(inner_wdata),
    .inner_ack(inner_ack), .inner_rdata(inner_rdata)
  );

  int errors = 0;
  int checks = 0;
  int lat = 1;
  logic [31:0] mem [16];
  logic [31:0] ref_mem [16];

  function automatic int idx(input logic [15:0] a);
    return {a[12], a[4:2]};
  endfunction

  // Inner register model: ack in busy cycle lat (0 = never).
  initial begin
    int cyc;
    cyc = 0;
    for (int i = 0; i < 16; i++) mem[i] = 32'h1000_0000 + i * 32'h111;
    forever begin
      @(negedge clk);
      if (inner_req) begin
        cyc++;
        if (lat != 0 && cyc == lat) begin
          model_ack = 1'b1;
          if (inner_we) mem[idx(inner_addr)] = inner_wdata;
          else          model_rdata = mem[idx(inner_addr)];
        end else model_ack = 1'b0;
      end else begin
        cyc = 0;
        model_ack = 1'b0;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr_en = 1'b1;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic hread(input logic [3:0] a, output logic [31:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic wait_idle(output int n);
    logic [31:0] v;
    n = 0;
    forever begin
      hread(4'h4, v);
      if (!v[31] || n > 100) break;
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v, d, x;
    logic [15:0] a, a2;
    int n, span;
    for (int i = 0; i < 16; i++) ref_mem[i] = 32'h1000_0000 + i * 32'h111;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    hread(4'h0, v); chk("R1 data", v, 32'h0);
    hread(4'h4, v); chk("R1 cmd", v, 32'h0);
    chk("R1 req", {31'b0, inner_req}, 32'h0);

    for (int L = 1; L <= W + 2; L++) begin
      a = 16'((L * 4) & 16'h1C) | ((L[0]) ? 16'h1000 : 16'h0000);
      d = 32'hA500_0000 ^ (L << 8) ^ 32'(a);
      span = ibr_pkg::busy_span(L, W);
      // write access
      hwrite(4'h0, d);
      hread(4'h0, v); chk("R2 data load", v, d);
      lat = L;
      hwrite(4'h4, 32'(a) | 32'h1000_0000);
      chk("R3 req", {31'b0, inner_req}, 32'h1);
      chk("R3 we", {31'b0, inner_we}, 32'h1);
      chk("R3 addr", 32'(inner_addr), 32'(a));
      chk("R3 wdata", inner_wdata, d);
      hread(4'h4, v); chk("R9 cmd view", v, 32'h9000_0000 | 32'(a));
      wait_idle(n);
      chk(L <= W ? "R5 write span" : "R8 write span", n, span);
      hread(4'h4, v); chk("R8 tmo flag", {31'b0, v[26]}, {31'b0, L > W});
      if (L <= W) ref_mem[idx(a)] = d;
      // read access
      hwrite(4'h4, 32'(a));
      chk("R3 read dir", {31'b0, inner_we}, 32'h0);
      hread(4'h4, v); chk("R9 error cleared", {30'b0, v[27:26]}, 32'h0);
      wait_idle(n);
      chk(L <= W ? "R5 read span" : "R8 read span", n, span);
      hread(4'h0, v);
      chk(L <= W ? "R4 read data" : "R8 data kept", v, L <= W ? ref_mem[idx(a)] : d);
    end

    // overrun and dropped data writes during a busy write
    lat = 6;
    a = 16'h0008; a2 = 16'h100C; x = 32'h5EED_F00D;
    hwrite(4'h0, x);
    hwrite(4'h4, 32'(a) | 32'h1000_0000);
    hwrite(4'h4, 32'(a2) | 32'h1000_0000);
    chk("R6 addr kept", 32'(inner_addr), 32'(a));
    hread(4'h4, v); chk("R6 ovr set", {31'b0, v[27]}, 32'h1);
    hwrite(4'h0, 32'hFFFF_0000);
    hread(4'h0, v); chk("R7 data kept busy", v, x);
    wait_idle(n);
    hread(4'h0, v); chk("R7 data kept after", v, x);
    hread(4'h4, v); chk("R6 ovr sticky", {31'b0, v[27]}, 32'h1);
    ref_mem[idx(a)] = x;
    lat = 2;
    hwrite(4'h4, 32'(a2));
    hread(4'h4, v); chk("R9 ovr cleared", {31'b0, v[27]}, 32'h0);
    wait_idle(n);
    hread(4'h0, v); chk("R6 second target untouched", v, ref_mem[idx(a2)]);
    hwrite(4'h4, 32'(a));
    wait_idle(n);
    hread(4'h0, v); chk("R6 first target written", v, x);

    // stray ack while idle
    hwrite(4'h0, 32'h0123_4567);
    @(negedge clk); stray_ack = 1'b1;
    @(negedge clk); stray_ack = 1'b0;
    hread(4'h0, v); chk("R10 data", v, 32'h0123_4567);
    hread(4'h4, v); chk("R10 busy", {31'b0, v[31]}, 32'h0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule